// File: doc/BRIEF.md
# Fuse-Configured Product-Term Logic Core

This block is the logic heart of a small programmable device. A static configuration vector selects which signals take part in each of forty product terms. It also sets, for each of ten output cells, the cell's function and output polarity, and it carries one global routing bit. Twenty signals reach the array, each in true and inverted form, giving forty columns. The twenty signals are ten dedicated input pins, the cell feedbacks, and, in one routing mode, the levels of the clock pad and the shared active-low enable pad.

Each output cell takes four product terms. It behaves as one of four things: a registered sum of three terms, a combinational sum of three terms, a registered two-by-two exclusive-OR, or a combinational two-by-two exclusive-OR. The output value and output-enable of each cell are brought out separately, so a pad ring can build the tri-state pins. The pad level of each pin is returned on a separate input and used as feedback for combinational cells. How the vector gets loaded is outside this block.

Top module: `plc_fuse_core`

## Requirements
- R1: A product term is the AND of every column whose fuse bit is 1. A term with all 40 fuse bits at 1 is 0, and a term with all 40 fuse bits at 0 is 1.
- R2: Term r of cell c uses fuse bits (4c+r)*40 to (4c+r)*40+39, with fuse (4c+r)*40+k selecting column k. The polarity bit of cell c is fuse 1600+c, its function bits are ac0 = fuse 1610+c and ac1 = fuse 1620+c, and the routing bit is fuse 1630.
- R3: Signal slot s drives column 2s in true form and column 2s+1 inverted. Slots 0 to 9 carry in_pins[0..9], and slots 10 to 17 carry the feedback of cells 1 to 8.
- R4: When the routing bit is 1, slot 18 carries clk_pad and slot 19 carries oe_n, and cells 0 and 9 reach no column.
- R5: When the routing bit is 0, slot 18 carries the feedback of cell 0 and slot 19 that of cell 9.
- R6: Registered cell (ac1=0, ac0=1): on each rising clk, pin_out takes t0|t1|t2 when polarity is 0 and its inverse when polarity is 1. pin_oe follows t3.
- R7: Combinational cell (ac1=1, ac0=1): pin_out is (t0|t1|t2) XOR polarity without delay, and pin_oe follows t3.
- R8: Combinational XOR cell (ac1=1, ac0=0): pin_out is the inverse of (t0|t1) XOR (t2|t3), and pin_oe is the inverse of oe_n.
- R9: Registered XOR cell (ac1=0, ac0=0): on each rising clk, pin_out takes the inverse of (t0|t1) XOR (t2|t3), and pin_oe is the inverse of oe_n.
- R10: A clock edge with rst_n low clears every cell register, so every registered cell's pin_out reads 1 whatever its polarity.
- R11: A registered cell feeds back its register state, true form equal to the inverse of its pin_out. A combinational cell feeds back its io_in pad level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all cell registers |
| rst_n | input | 1 | Synchronous active-low reset of the cell registers |
| clk_pad | input | 1 | Level of the clock pad, used as array data in routing mode 1 |
| oe_n | input | 1 | Shared active-low enable for XOR cells, also array data in routing mode 1 |
| in_pins | input | 10 | Dedicated input pins |
| io_in | input | 10 | Pad level of each output pin, fed back by combinational cells |
| fuses | input | 1631 | Static configuration vector |
| pin_out | output | 10 | Output value of each cell |
| pin_oe | output | 10 | Output enable of each cell |

## Verification
Sparse random fuse rows set about one bit in sixteen. This leaves a mix of always-true terms, terms that depend on two or three signals, and terms that are false because they hold a signal and its inverse. Random pad and input values then separate wrong column order, wrong true/inverse pairing and a wrong feedback source. Every random phase also picks random function bits, polarity and routing bit, so all four cell functions meet both routing modes. Directed patterns isolate single columns: one input pin, clk_pad in slot 18, cell-0 feedback in the same slot, and a registered cell's state read by a neighbour. These expose a swapped routing mode or a lost end-cell feedback that random terms could mask. Fully set and fully cleared rows check the two extremes of a term.

// File: rtl/plc_pkg.sv
// Shared types of the fuse-configured logic core.
// Assumes the function field is ordered {ac1, ac0}.
package plc_pkg;
    typedef enum logic [1:0] {
        CFG_XOR_REG = 2'b00,
        CFG_REG     = 2'b01,
        CFG_XOR_CMB = 2'b10,
        CFG_CMB     = 2'b11
    } cell_cfg_e;

    typedef struct packed {
        logic      pol;
        cell_cfg_e cfg;
    } cell_ctl_t;
endpackage

// File: rtl/plc_and_array.sv
// Product-term array: each row ANDs the columns whose fuse bit is 1.
// Assumes fuses are row-major, N_COL bits per row, bit k selecting column k.
module plc_and_array #(
    parameter int N_ROW = 40,
    parameter int N_COL = 40
) (
    input  logic [N_ROW*N_COL-1:0] fuse_rows,
    input  logic [N_COL-1:0]       cols,
    output logic [N_ROW-1:0]       terms
);
    // One AND gate per row; a blown fuse forces its column to 1.
    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        assign terms[r] = &(~fuse_rows[r*N_COL +: N_COL] | cols);
    end
endmodule

// File: rtl/plc_route.sv
// Signal router: picks the signal of each array slot from the routing bit
// and drives each slot as a true/inverted column pair.
// Assumes N_SIG = N_IN + N_CELL, with the two end cells sharing the last
// two slots with the clock and enable pads.
module plc_route #(
    parameter int N_IN   = 10,
    parameter int N_CELL = 10,
    localparam int N_SIG = N_IN + N_CELL,
    localparam int N_COL = 2 * N_SIG
) (
    input  logic              mode,
    input  logic              clk_pad,
    input  logic              oe_n,
    input  logic [N_IN-1:0]   in_pins,
    input  logic [N_CELL-1:0] fb,
    output logic [N_COL-1:0]  cols
);
    logic [N_SIG-1:0] sig;

    // Slot assignment: inputs, inner feedbacks, then the two shared slots.
    always_comb begin
        sig[N_IN-1:0]              = in_pins;
        sig[N_SIG-3:N_IN]          = fb[N_CELL-2:1];
        sig[N_SIG-2]               = mode ? clk_pad : fb[0];
        sig[N_SIG-1]               = mode ? oe_n    : fb[N_CELL-1];
    end

    // Each slot becomes a true column followed by an inverted column.
    for (genvar s = 0; s < N_SIG; s++) begin : g_pair
        assign cols[2*s]     = sig[s];
        assign cols[2*s + 1] = ~sig[s];
    end
endmodule

// File: rtl/plc_cell.sv
// Output cell: forms a sum or XOR of its four terms, optionally registers
// it, and produces output value, output enable and feedback.
// Assumes term 3 is the enable term for the non-XOR functions.
module plc_cell
    import plc_pkg::*;
#(
    parameter int N_PT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_PT-1:0] terms,
    input  cell_ctl_t       ctl,
    input  logic            oe_n,
    input  logic            io_in,
    output logic            pin_out,
    output logic            pin_oe,
    output logic            fb
);
    logic sum3, xv, d, q, registered;

    // Combine the terms and choose the register input.
    always_comb begin
        sum3       = terms[0] | terms[1] | terms[2];
        xv         = (terms[0] | terms[1]) ^ (terms[2] | terms[N_PT-1]);
        registered = ~ctl.cfg[1];
        d          = (ctl.cfg == CFG_XOR_REG) ? xv : (ctl.pol ? sum3 : ~sum3);
    end

    // Cell register: cleared by reset, loaded only in registered functions.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (registered)
            q <= d;
    end

    // Output value, enable and feedback selection.
    always_comb begin
        case (ctl.cfg)
            CFG_CMB:     pin_out = sum3 ^ ctl.pol;
            CFG_XOR_CMB: pin_out = ~xv;
            default:     pin_out = ~q;
        endcase
        pin_oe = ctl.cfg[0] ? terms[N_PT-1] : ~oe_n;
        fb     = registered ? q : io_in;
    end

    // R6 R9: a registered cell captures its computed input on each edge.
    assert_reg_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        registered |=> (q == $past(d)));

    // R10: the first edge out of reset finds the register cleared.
    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q == 1'b0));
endmodule

// File: rtl/plc_fuse_core.sv
// Top of the fuse-configured logic core: decodes the fixed fuse map,
// routes signals into the array and instantiates the output cells.
// Assumes the fuse vector is static while the core runs.
module plc_fuse_core
    import plc_pkg::*;
#(
    parameter int N_IN   = 10,
    parameter int N_CELL = 10,
    parameter int N_PT   = 4,
    localparam int N_SIG     = N_IN + N_CELL,
    localparam int N_COL     = 2 * N_SIG,
    localparam int N_ROW     = N_CELL * N_PT,
    localparam int POL_BASE  = N_ROW * N_COL,
    localparam int AC0_BASE  = POL_BASE + N_CELL,
    localparam int AC1_BASE  = AC0_BASE + N_CELL,
    localparam int MODE_BIT  = AC1_BASE + N_CELL,
    localparam int FUSE_BITS = MODE_BIT + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_pad,
    input  logic                 oe_n,
    input  logic [N_IN-1:0]      in_pins,
    input  logic [N_CELL-1:0]    io_in,
    input  logic [FUSE_BITS-1:0] fuses,
    output logic [N_CELL-1:0]    pin_out,
    output logic [N_CELL-1:0]    pin_oe
);
    logic [N_COL-1:0]  cols;
    logic [N_ROW-1:0]  terms;
    logic [N_CELL-1:0] fb;
    cell_ctl_t         ctl [N_CELL];
    logic              mode;

    assign mode = fuses[MODE_BIT];

    plc_route #(.N_IN(N_IN), .N_CELL(N_CELL)) i_route (
        .mode    (mode),
        .clk_pad (clk_pad),
        .oe_n    (oe_n),
        .in_pins (in_pins),
        .fb      (fb),
        .cols    (cols)
    );

    plc_and_array #(.N_ROW(N_ROW), .N_COL(N_COL)) i_array (
        .fuse_rows (fuses[POL_BASE-1:0]),
        .cols      (cols),
        .terms     (terms)
    );

    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
        // Per-cell control bits gathered from their fixed fuse addresses.
        always_comb begin
            ctl[c].pol = fuses[POL_BASE + c];
            ctl[c].cfg = cell_cfg_e'({fuses[AC1_BASE + c], fuses[AC0_BASE + c]});
        end

        plc_cell #(.N_PT(N_PT)) i_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .terms   (terms[c*N_PT +: N_PT]),
            .ctl     (ctl[c]),
            .oe_n    (oe_n),
            .io_in   (io_in[c]),
            .pin_out (pin_out[c]),
            .pin_oe  (pin_oe[c]),
            .fb      (fb[c])
        );
    end

    // R1: a row with every fuse bit set holds a signal and its inverse.
    for (genvar r = 0; r < N_ROW; r++) begin : g_row_chk
        assert_full_row_false_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (&fuses[r*N_COL +: N_COL]) |-> !terms[r]);
    end

    // R4: in routing mode 1 the clock pad occupies the first shared slot.
    assert_clk_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode |-> (cols[2*(N_SIG-2)] == clk_pad));

    // R5: in routing mode 0 the last cell's feedback occupies the last slot.
    assert_end_fb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> (cols[2*(N_SIG-1)] == fb[N_CELL-1]));
endmodule

// File: tb/test_plc_fuse_core.sv
module test_plc_fuse_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_pad = 1'b0;
    logic         oe_n = 1'b1;
    logic [9:0]   in_pins = '0;
    logic [9:0]   io_in = '0;
    logic [1630:0] fz = '0;
    logic [9:0]   pin_out, pin_oe;
    logic [9:0]   q_m = '0;
    int           checks = 0;
    int           fails = 0;
    bit           done = 0;

    always #10 clk = ~clk;

    plc_fuse_core i_plc_fuse_core (
        .clk(clk), .rst_n(rst_n), .clk_pad(clk_pad), .oe_n(oe_n),
        .in_pins(in_pins), .io_in(io_in), .fuses(fz),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Requirement tag for a cell's function.
    function automatic string cfg_tag(input int c);
        case ({fz[1620+c], fz[1610+c]})
            2'b00:   return "R9";
            2'b01:   return "R6";
            2'b10:   return "R8";
            default: return "R7";
        endcase
    endfunction

    // Independent model of the core built from the requirements.
    task automatic model(output logic [9:0] eo, output logic [9:0] eoe, output logic [9:0] ed);
        logic [19:0] sig;
        logic [39:0] cols;
        logic [39:0] t;
        logic [9:0]  fb;
        logic [3:0]  p;
        logic        sum, xv, pol, a0, a1;
        for (int c = 0; c < 10; c++) fb[c] = fz[1620+c] ? io_in[c] : q_m[c]; // R11
        for (int s = 0; s < 10; s++) sig[s] = in_pins[s];                    // R3
        for (int c = 1; c < 9; c++) sig[9+c] = fb[c];
        sig[18] = fz[1630] ? clk_pad : fb[0];                                 // R4 R5
        sig[19] = fz[1630] ? oe_n : fb[9];
        for (int s = 0; s < 20; s++) begin
            cols[2*s] = sig[s];
            cols[2*s+1] = ~sig[s];
        end
        for (int r = 0; r < 40; r++) t[r] = &(~fz[r*40 +: 40] | cols);      // R1 R2
        for (int c = 0; c < 10; c++) begin
            p = t[4*c +: 4];
            pol = fz[1600+c]; a0 = fz[1610+c]; a1 = fz[1620+c];
            sum = p[0] | p[1] | p[2];
            xv = (p[0] | p[1]) ^ (p[2] | p[3]);
            eoe[c] = a0 ? p[3] : ~oe_n;
            ed[c] = (!a0 && !a1) ? xv : (pol ? sum : ~sum);
            case ({a1, a0})
                2'b11:   eo[c] = sum ^ pol;
                2'b10:   eo[c] = ~xv;
                default: eo[c] = ~q_m[c];
            endcase
        end
    endtask

    // One vector: compare mid low phase, then advance the model at the edge.
    task automatic vec(input string tag);
        logic [9:0] eo, eoe, ed;
        #5;
        model(eo, eoe, ed);
        checks++;
        if (pin_out !== eo || pin_oe !== eoe) begin
            fails++;
            for (int c = 0; c < 10; c++)
                if (pin_out[c] !== eo[c] || pin_oe[c] !== eoe[c])
                    $display("FAIL %s %s cell %0d: out=%b oe=%b expected out=%b oe=%b",
                             tag, cfg_tag(c), c, pin_out[c], pin_oe[c], eo[c], eoe[c]);
        end
        @(posedge clk);
        if (!rst_n) q_m = '0;
        else for (int c = 0; c < 10; c++) if (!fz[1620+c]) q_m[c] = ed[c];
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        vec("R10");
        vec("R10");
        rst_n = 1'b1;
    endtask

    task automatic set_cell(input int c, input logic a1, input logic a0, input logic pol);
        fz[1620+c] = a1; fz[1610+c] = a0; fz[1600+c] = pol;
    endtask

    // Directed base: every term false, every cell combinational, polarity 0.
    task automatic clean_base(input logic md);
        fz[1599:0] = '1;
        for (int c = 0; c < 10; c++) set_cell(c, 1'b1, 1'b1, 1'b0);
        fz[1630] = md;
    endtask

    task automatic set_row(input int r, input logic [39:0] sel);
        fz[r*40 +: 40] = sel;
    endtask

    initial begin : watchdog
        #(20 * 100000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd7741));
        // Random phases over all functions and both routing modes.
        for (int ph = 0; ph < 20; ph++) begin
            for (int i = 0; i < 1600; i++) fz[i] = (($urandom % 16) == 0);
            for (int i = 1600; i < 1631; i++) fz[i] = $urandom % 2;
            do_reset();
            for (int v = 0; v < 100; v++) begin
                in_pins = $urandom; io_in = $urandom;
                clk_pad = $urandom % 2; oe_n = $urandom % 2;
                vec("random");
            end
        end

        // R1: full row false, empty row true on the enable term of cell 0.
        clean_base(1'b0);
        do_reset();
        vec("R1 full row");
        set_row(3, 40'h0);
        vec("R1 empty row");

        // R3: only column 6 (in_pins[3] true) in term 0 of cell 1.
        clean_base(1'b0);
        set_row(4, 40'h1 << 6);
        for (int v = 0; v < 4; v++) begin
            in_pins = 10'(v[0]) << 3;
            vec("R3 column order");
        end
        // R3: column 7 is the inverted form of the same pin.
        set_row(4, 40'h1 << 7);
        for (int v = 0; v < 4; v++) begin
            in_pins = 10'(v[0]) << 3;
            vec("R3 inverted column");
        end

        // R2: polarity fuse 1601 flips cell 1.
        fz[1601] = 1'b1;
        vec("R2 polarity bit");

        // R4: mode 1, slots 18 and 19 read the pads, cell 0 does not reach them.
        clean_base(1'b1);
        set_row(16, 40'h1 << 36);
        set_row(20, 40'h1 << 38);
        for (int v = 0; v < 8; v++) begin
            clk_pad = v[0]; oe_n = v[1]; io_in = {10{v[2]}};
            vec("R4 pad slots");
        end

        // R5: mode 0, the same columns carry cell 0 and cell 9 feedback.
        fz[1630] = 1'b0;
        for (int v = 0; v < 8; v++) begin
            clk_pad = v[0]; oe_n = v[1]; io_in = {v[2], 8'h00, ~v[2]};
            vec("R5 end feedback");
        end

        // R11: registered cell 2 feeds back state (slot 11 -> column 22).
        clean_base(1'b0);
        set_cell(2, 1'b0, 1'b1, 1'b0);
        set_row(8, 40'h1 << 6);
        set_row(20, 40'h1 << 22);
        do_reset();
        for (int v = 0; v < 6; v++) begin
            in_pins = 10'(v[1]) << 3; io_in = {10{v[0]}};
            vec("R11 register feedback");
        end

        // R6 R9 R10: registered cells with polarity 1 still read 1 after reset.
        clean_base(1'b0);
        set_cell(0, 1'b0, 1'b1, 1'b1);
        set_cell(1, 1'b0, 1'b0, 1'b1);
        set_row(0, 40'h0);
        set_row(4, 40'h0);
        do_reset();
        vec("R6 R9 registered load");
        vec("R6 R9 registered hold");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule